// File: doc/BRIEF.md
# Dual-Rate Sample Output Demultiplexer

This block sits behind a converter's sample stream. It accepts one 8-bit sample per sample-clock cycle and hands it out on two output ports, A and B. In pair mode, accepted samples are collected two at a time: the first of each pair goes to A and the second goes to B. Both ports then update together, at half the sample rate. In single mode, every accepted sample lands on A and B is parked at all ones. A data-ready strobe comes out alongside the data. It toggles once per accepted sample, or, in pair mode with the quarter-rate option, once per two accepted samples.

Each word can be sent as straight binary or as Gray code. The coding is applied before the word is steered to a port. An asynchronous realignment input clears the pair phase, the strobe divider and the decimation counter, so that several devices can be brought into step. A decimation test mode passes only every DECIM_N-th sample. All configuration inputs are taken in only at a pair boundary, so a pair never mixes two settings.

Top module: `sample_demux`

## Requirements
- R1: In pair mode (`pair_mode_i`=1), the first accepted sample after a boundary is held internally and the ports do not change. On the second accepted sample, the clock edge that takes it in loads A with the held word and B with the new word, both in the same edge.
- R2: In single mode (`pair_mode_i`=0), the clock edge that accepts a sample loads it onto A and sets B to 8'hFF.
- R3: A 2-bit strobe divider counts accepted samples. `dr_o` equals divider bit 1 when the active configuration has pair mode and `dr_quarter_i`=1. Otherwise `dr_o` equals divider bit 0, so it toggles on every accepted sample.
- R4: With `gray_i`=1, the word sent out is s XOR (s >> 1), for example 8'hB4 becomes 8'hEE. With `gray_i`=0 the word is s unchanged.
- R5: While `drr_i`=1, `dr_o` is 0, the pair phase points at A, no sample is accepted, and both ports hold their values. Assertion of `drr_i` takes effect without waiting for a clock edge.
- R6: After `drr_i` falls, the first accepted sample is the A half of a pair. The strobe starts from its low phase: `dr_o` goes high after the first accepted sample in half-rate strobe mode, and after the second in quarter-rate mode.
- R7: With `decim_i`=1, a sample is accepted only in cycles where a free-running counter of period DECIM_N is zero. That counter is cleared by reset and by `drr_i`. A sample that is not accepted changes neither the ports, nor the phase, nor the strobe.
- R8: `pair_mode_i`, `dr_quarter_i`, `gray_i` and `decim_i` are taken in only in cycles where no A half is waiting. While a half pair is waiting, the setting in force when its A half was taken stays active.
- R9: After `rst_n` is asserted, port A is 8'h00, port B is 8'hFF, `dr_o` is 0, and the active configuration is single mode, binary, half-rate strobe, no decimation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drr_i | input | 1 | Asynchronous active-high data-ready realignment |
| smp_i | input | W | Incoming sample, one per clock |
| pair_mode_i | input | 1 | 1: two-port pair mode, 0: single-port mode |
| dr_quarter_i | input | 1 | 1: strobe at a quarter of the sample rate (pair mode only) |
| gray_i | input | 1 | 1: Gray-coded outputs, 0: binary |
| decim_i | input | 1 | 1: decimation test mode |
| port_a_o | output | W | Output port A |
| port_b_o | output | W | Output port B |
| dr_o | output | 1 | Data-ready strobe |

## Verification
The bench targets these cases:

- **Setting change halfway through a pair.** A design that applies the new setting at once would send the B half in the wrong mode or coding, or would drop the waiting A word.
- **Realignment pulse in the middle of a pair.** The following first sample must be an A half, and the strobe must restart low. A design that kept the old phase would swap the ports. One that kept the divider would start the strobe high.
- **Decimation with the counter running.** Skipped samples must leave the ports and the strobe untouched. A design that advanced the divider on every clock would drift the strobe away from the data.
- **Random settings and realignment pulses.** These are mixed in to reach orderings that the directed cases miss.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    // Active configuration of the demultiplexer
    typedef struct packed {
        logic pair;   // 1: two-port pair mode
        logic fs4;    // 1: quarter-rate strobe in pair mode
        logic gray;   // 1: Gray-coded output words
        logic decim;  // 1: decimation test mode
    } dmx_cfg_t;

    localparam dmx_cfg_t CFG_RESET = '{pair: 1'b0, fs4: 1'b0, gray: 1'b0, decim: 1'b0};

endpackage

// File: rtl/dmx_coder.sv
module dmx_coder #(
    parameter int W = 8
) (
    input  logic [W-1:0] word_i,
    input  logic         gray_i,
    output logic [W-1:0] word_o
);

    logic [W-1:0] gray_w;

    // Each Gray bit is the XOR of a binary bit with its upper neighbour
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == W - 1) begin : g_top
            assign gray_w[i] = word_i[i];
        end else begin : g_low
            assign gray_w[i] = word_i[i] ^ word_i[i+1];
        end
    end

    assign word_o = gray_i ? gray_w : word_i;

endmodule

// File: rtl/dmx_pacer.sv
module dmx_pacer
    import dmx_pkg::*;
#(
    parameter int DECIM_N = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_n,    // reset or realignment, active low
    input  logic     drr_i,
    input  logic     acc_i,    // a sample is accepted this cycle
    input  dmx_cfg_t cfg_q_i,  // registered active configuration
    output logic     slot_o,   // decimation counter at zero
    output logic     dr_o
);

    localparam int CW = (DECIM_N > 2) ? $clog2(DECIM_N) : 1;
    localparam logic [CW-1:0] LAST = CW'(DECIM_N - 1);

    typedef struct packed {
        logic [1:0]    div;
        logic [CW-1:0] dcnt;
    } pace_t;

    pace_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (acc_i) begin
            st_d.div = st_q.div + 2'd1;
        end
        st_d.dcnt = (st_q.dcnt == LAST) ? '0 : st_q.dcnt + 1'b1;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o = (st_q.dcnt == '0);
    assign dr_o   = (cfg_q_i.pair && cfg_q_i.fs4) ? st_q.div[1] : st_q.div[0];

    AST_DR_LOW_IN_DRR: assert property (@(posedge clk) disable iff (!rst_n)
        drr_i |-> !dr_o); // R5

    AST_DIV_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n || drr_i)
        !acc_i |=> $stable(st_q.div)); // R7

endmodule

// File: rtl/dmx_router.sv
module dmx_router
    import dmx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         drr_i,
    input  logic         acc_i,
    input  dmx_cfg_t     cfg_i,     // configuration pins
    input  logic [W-1:0] coded_i,   // coded sample word
    output dmx_cfg_t     cfg_eff_o, // setting in force this cycle
    output dmx_cfg_t     cfg_q_o,
    output logic [W-1:0] port_a_o,
    output logic [W-1:0] port_b_o
);

    typedef struct packed {
        dmx_cfg_t     cfg;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } out_t;

    typedef struct packed {
        logic         phase;  // 1: an A half is waiting
        logic [W-1:0] pend;
    } hold_t;

    out_t  out_d, out_q;
    hold_t hld_d, hld_q;
    dmx_cfg_t eff;

    // New settings only at a pair boundary
    assign eff = hld_q.phase ? out_q.cfg : cfg_i;

    always_comb begin
        out_d     = out_q;
        hld_d     = hld_q;
        out_d.cfg = eff;
        if (acc_i) begin
            if (!eff.pair) begin
                out_d.a     = coded_i;
                out_d.b     = '1;
                hld_d.phase = 1'b0;
            end else if (!hld_q.phase) begin
                hld_d.pend  = coded_i;
                hld_d.phase = 1'b1;
            end else begin
                out_d.a     = hld_q.pend;
                out_d.b     = coded_i;
                hld_d.phase = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.cfg <= CFG_RESET;
            out_q.a   <= '0;
            out_q.b   <= '1;
        end else begin
            out_q <= out_d;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            hld_q <= '0;
        end else begin
            hld_q <= hld_d;
        end
    end

    assign cfg_eff_o = eff;
    assign cfg_q_o   = out_q.cfg;
    assign port_a_o  = out_q.a;
    assign port_b_o  = out_q.b;

    AST_B_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && !eff.pair) |=> (port_b_o == '1)); // R2

    AST_PAIR_FIRST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && eff.pair && !hld_q.phase) |=> ($stable(port_a_o) && $stable(port_b_o))); // R1

    AST_CFG_HOLD_MID_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        hld_q.phase |=> $stable(out_q.cfg)); // R8

    AST_DRR_PHASE_A: assert property (@(posedge clk) disable iff (!rst_n)
        drr_i |-> !hld_q.phase); // R5

endmodule

// File: rtl/sample_demux.sv
module sample_demux
    import dmx_pkg::*;
#(
    parameter int W       = 8,
    parameter int DECIM_N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drr_i,
    input  logic [W-1:0] smp_i,
    input  logic         pair_mode_i,
    input  logic         dr_quarter_i,
    input  logic         gray_i,
    input  logic         decim_i,
    output logic [W-1:0] port_a_o,
    output logic [W-1:0] port_b_o,
    output logic         dr_o
);

    dmx_cfg_t     cfg_pins, cfg_eff, cfg_q;
    logic [W-1:0] coded;
    logic         slot, acc, clr_n;

    assign cfg_pins = '{pair: pair_mode_i, fs4: dr_quarter_i, gray: gray_i, decim: decim_i};
    assign clr_n    = rst_n & ~drr_i;
    assign acc      = ~drr_i & (~cfg_eff.decim | slot);

    dmx_coder #(.W(W)) u_coder (
        .word_i (smp_i),
        .gray_i (cfg_eff.gray),
        .word_o (coded)
    );

    dmx_router #(.W(W)) u_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .drr_i     (drr_i),
        .acc_i     (acc),
        .cfg_i     (cfg_pins),
        .coded_i   (coded),
        .cfg_eff_o (cfg_eff),
        .cfg_q_o   (cfg_q),
        .port_a_o  (port_a_o),
        .port_b_o  (port_b_o)
    );

    dmx_pacer #(.DECIM_N(DECIM_N)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .drr_i   (drr_i),
        .acc_i   (acc),
        .cfg_q_i (cfg_q),
        .slot_o  (slot),
        .dr_o    (dr_o)
    );

    AST_IDLE_PORTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(port_a_o) && $stable(port_b_o))); // R7

    AST_DR_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n || drr_i)
        (acc && !(cfg_eff.pair && cfg_eff.fs4) && !(cfg_q.pair && cfg_q.fs4))
        |=> (dr_o != $past(dr_o))); // R3

endmodule

// File: tb/sample_demux_tb.sv
module sample_demux_tb;

    localparam int W  = 8;
    localparam int DN = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         drr = 1'b0;
    logic [W-1:0] smp = '0;
    logic         pair = 1'b0, fs4 = 1'b0, gray = 1'b0, decim = 1'b0;
    logic [W-1:0] pa, pb;
    logic         dr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    logic         m_phase, m_cpair, m_cfs4, m_cgray, m_cdec;
    logic [W-1:0] m_pend, m_a, m_b;
    logic [1:0]   m_div;
    int           m_dcnt;

    always #5 clk = ~clk;

    sample_demux #(.W(W), .DECIM_N(DN)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .drr_i        (drr),
        .smp_i        (smp),
        .pair_mode_i  (pair),
        .dr_quarter_i (fs4),
        .gray_i       (gray),
        .decim_i      (decim),
        .port_a_o     (pa),
        .port_b_o     (pb),
        .dr_o         (dr)
    );

    function automatic logic [W-1:0] to_gray(input logic [W-1:0] s);
        return s ^ (s >> 1);
    endfunction

    function automatic logic exp_dr();
        return (m_cpair && m_cfs4) ? m_div[1] : m_div[0];
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%02h expected=%02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_phase = 0; m_pend = '0; m_a = '0; m_b = '1; m_div = '0; m_dcnt = 0;
        m_cpair = 0; m_cfs4 = 0; m_cgray = 0; m_cdec = 0;
    endtask

    task automatic model_edge();
        logic ep, ef, eg, ed, acc;
        logic [W-1:0] cw;
        if (drr) begin
            m_phase = 0; m_pend = '0; m_div = '0; m_dcnt = 0;
            m_cpair = pair; m_cfs4 = fs4; m_cgray = gray; m_cdec = decim;
            return;
        end
        if (m_phase) begin
            ep = m_cpair; ef = m_cfs4; eg = m_cgray; ed = m_cdec;
        end else begin
            ep = pair; ef = fs4; eg = gray; ed = decim;
        end
        acc = !ed || (m_dcnt == 0);
        cw  = eg ? to_gray(smp) : smp;
        if (acc) begin
            if (!ep) begin
                m_a = cw; m_b = '1;
            end else if (!m_phase) begin
                m_pend = cw; m_phase = 1;
            end else begin
                m_a = m_pend; m_b = cw; m_phase = 0;
            end
            m_div = m_div + 2'd1;
        end
        m_dcnt = (m_dcnt == DN - 1) ? 0 : m_dcnt + 1;
        m_cpair = ep; m_cfs4 = ef; m_cgray = eg; m_cdec = ed;
    endtask

    task automatic compare(input string tag);
        chk(pa == m_a, tag, "port_a", pa, m_a);
        chk(pb == m_b, tag, "port_b", pb, m_b);
        chk(dr == exp_dr(), "R3", "dr", {7'd0, dr}, {7'd0, exp_dr()});
    endtask

    // Called at a falling edge: drive, advance model, compare after the next rising edge
    task automatic cyc(input logic d, input logic [W-1:0] s, input logic p, input logic f,
                       input logic g, input logic m, input string tag);
        drr = d; smp = s; pair = p; fs4 = f; gray = g; decim = m;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(pa == 8'h00, "R9", "port_a reset", pa, 8'h00);
        chk(pb == 8'hFF, "R9", "port_b reset", pb, 8'hFF);
        chk(dr == 1'b0, "R9", "dr reset", {7'd0, dr}, 8'h00);

        // R2: single mode, binary
        cyc(0, 8'h3C, 0, 0, 0, 0, "R2");
        chk(pa == 8'h3C && pb == 8'hFF, "R2", "single mode A", pa, 8'h3C);
        // R4: Gray coding
        cyc(0, 8'hB4, 0, 0, 1, 0, "R4");
        chk(pa == 8'hEE, "R4", "gray word", pa, 8'hEE);

        // R5 / R6: realignment, then pair mode with half-rate strobe
        cyc(1, 8'h99, 1, 0, 0, 0, "R5");
        chk(dr == 1'b0 && pa == 8'hEE, "R5", "held during drr", pa, 8'hEE);
        cyc(0, 8'h11, 1, 0, 0, 0, "R6");
        chk(pa == 8'hEE && dr == 1'b1, "R6", "first half held, dr high", pa, 8'hEE);
        cyc(0, 8'h22, 1, 0, 0, 0, "R1");
        chk(pa == 8'h11 && pb == 8'h22, "R1", "pair A", pa, 8'h11);

        // R3: quarter-rate strobe after realignment
        cyc(1, 8'h00, 1, 1, 0, 0, "R5");
        cyc(0, 8'h31, 1, 1, 0, 0, "R6");
        chk(dr == 1'b0, "R6", "quarter dr after first", {7'd0, dr}, 8'h00);
        cyc(0, 8'h32, 1, 1, 0, 0, "R3");
        chk(dr == 1'b1, "R3", "quarter dr after second", {7'd0, dr}, 8'h01);
        for (int i = 0; i < 6; i++) cyc(0, 8'(8'h40 + i), 1, 1, 0, 0, "R3");

        // R8: settings change while an A half is waiting
        cyc(0, 8'h5A, 1, 0, 0, 0, "R8");
        cyc(0, 8'h7E, 0, 0, 1, 0, "R8");
        chk(pa == 8'h5A && pb == 8'h7E, "R8", "B kept old setting", pb, 8'h7E);
        cyc(0, 8'h7E, 0, 0, 1, 0, "R8");
        chk(pa == to_gray(8'h7E) && pb == 8'hFF, "R8", "new setting at boundary", pa, to_gray(8'h7E));

        // R7: decimation
        cyc(1, 8'h00, 0, 0, 0, 1, "R5");
        for (int i = 0; i < 12; i++) cyc(0, 8'(8'h80 + i), 0, 0, 0, 1, "R7");
        chk(pa == 8'h88, "R7", "decimated word", pa, 8'h88);
        for (int i = 0; i < 12; i++) cyc(0, 8'(8'hA0 + i), 1, i[0], 1, 1, "R7");

        // Mixed random phase
        for (int i = 0; i < 4000; i++) begin
            logic d;
            d = ($urandom % 48) == 0;
            if (($urandom % 12) == 0) begin
                pair  = $urandom; fs4 = $urandom;
                gray  = $urandom; decim = (($urandom % 4) == 0);
            end
            cyc(d, 8'($urandom), pair, fs4, gray, decim, m_cpair ? "R1" : "R2");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule